// File: doc/BRIEF.md
# Interrupt Claim and Notify Core

This block arbitrates level-sensitive interrupt sources for a configurable set of targets, called contexts. Every source carries a pending flag that tracks its input level and a claimed flag that hides it from all contexts while a handler owns it. Each source also holds a three-bit priority. Each context holds a per-source enable mask and a three-bit threshold. A context's notify line rises whenever at least one source is pending, not claimed, enabled for that context, and of a priority strictly above the context threshold.

A single command port carries claim and complete requests. A claim grants the lowest-numbered qualifying source of the named context. The scan runs group by group, in 32-source groups from the bottom, and does not prefer higher priorities. The grant clears the source's pending flag, sets its claimed flag, and returns its number one cycle later. A complete releases a claimed source. A small write port loads priorities, enable bits and thresholds. The surrounding system owns the register decode and the wiring of each notify line to a processor interrupt input.

Top module: `ic_core`

## Requirements
- R1: A source counts for a context only when it is pending, not claimed and enabled for that context; a claimed source is hidden from every context.
- R2: A counted source qualifies only if its priority is strictly greater than the context threshold; equal priority never qualifies.
- R3: `notify[c]` is high exactly when at least one source qualifies for context c, and it follows state changes in the cycle after the edge that made them.
- R4: A claim (`cmd_op`=0) grants the lowest-numbered qualifying source of `cmd_ctx`, scanning upward across 32-source groups, whatever the priorities of higher-numbered sources.
- R5: A claim makes `rsp_valid` high in the next cycle with `rsp_id` holding the granted number; the grant clears that source's pending flag and sets its claimed flag.
- R6: A claim that finds no qualifying source, or names a context at or above `N_CTX`, returns `rsp_id`=0 and changes no state.
- R7: A complete (`cmd_op`=1) clears the claimed flag of `cmd_id` only when `cmd_id` < `N_SRC`; a larger number has no effect.
- R8: A source's pending flag takes the level of `src_lvl` at each clock edge: high sets it and low clears it.
- R9: Priorities and thresholds span the full three-bit range 0 to 7; source 0 is never pending and never enabled, so an `rsp_id` of 0 always means no grant.
- R10: When a grant and a high source level meet the same source in one cycle, the grant's clearing of the pending flag wins for that cycle.
- R11: Synchronous active-low reset clears every pending, claimed, enable, priority and threshold value, and the response.
- R12: Configuration writes use `cfg_sel` 0 for the source priority of `cfg_idx`, 1 for enable bit `cfg_idx` of `cfg_ctx` taken from `cfg_data[0]`, and 2 for the threshold of `cfg_ctx`. Code 3, an index at or above `N_SRC` and a context at or above `N_CTX` are all ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | N_SRC | Source interrupt levels, bit i for source i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 priority, 1 enable, 2 threshold, 3 none |
| cfg_ctx | input | CTX_W | Context of an enable or threshold write |
| cfg_idx | input | ID_W | Source of a priority or enable write |
| cfg_data | input | PRIO_W | Written value (bit 0 for enable writes) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 claim, 1 complete |
| cmd_ctx | input | CTX_W | Context that claims |
| cmd_id | input | ID_W | Source number that completes |
| rsp_valid | output | 1 | Claim answer present |
| rsp_id | output | ID_W | Granted source, 0 for none |
| notify | output | N_CTX | Per-context interrupt notification |

## Verification
The bench targets three kinds of error. The first is a claim that favours a high-priority source over a lower-numbered one, or that stops at the first 32-source group; such a design returns the wrong number. The second is a threshold compared with greater-or-equal, which raises notify and grants sources whose priority merely equals the threshold. The third covers claimed sources and boundary inputs: a claimed source left visible keeps notify high after the grant, and an unguarded complete, out-of-range configuration write or live source 0 shows up as a changed notify or a non-zero `rsp_id` where none is allowed. Random traffic, compared every cycle against a behavioural model, covers the remaining combinations.

// File: rtl/ic_pkg.sv
// Shared encodings of the interrupt claim and notify core.
// Assumes: command and configuration codes are fixed by the block's ports.
package ic_pkg;

    localparam int GROUP_W = 32;

    typedef enum logic [1:0] {
        CFG_PRIO   = 2'd0,
        CFG_ENABLE = 2'd1,
        CFG_THRESH = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        OP_CLAIM    = 1'b0,
        OP_COMPLETE = 1'b1
    } cmd_op_e;

endpackage

// File: rtl/ic_src_state.sv
// Pending and claimed flags of every source.
// Pending follows the source level each edge unless a grant clears it;
// claimed is set by a grant and cleared by a complete.
// Assumes: grant and clear never name the same source in one cycle.
module ic_src_state #(
    parameter int N_SRC = 40,
    parameter int ID_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_lvl,
    input  logic             grant_en,
    input  logic [ID_W-1:0]  grant_id,
    input  logic             clr_en,
    input  logic [ID_W-1:0]  clr_id,
    output logic [N_SRC-1:0] pend,
    output logic [N_SRC-1:0] claimed
);

    localparam logic [N_SRC-1:0] LIVE_MASK = ~N_SRC'(1);

    logic [N_SRC-1:0] grant_oh;
    logic [N_SRC-1:0] clr_oh;

    // One-hot decode of the granted and the completed source.
    for (genvar s = 0; s < N_SRC; s++) begin : g_dec
        assign grant_oh[s] = grant_en && (grant_id == ID_W'(s));
        assign clr_oh[s]   = clr_en && (clr_id == ID_W'(s));
    end

    // Update the flags: a grant beats the source level; source 0 stays idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= '0;
            claimed <= '0;
        end else begin
            pend    <= src_lvl & ~grant_oh & LIVE_MASK;
            claimed <= ((claimed & ~clr_oh) | grant_oh) & LIVE_MASK;
        end
    end

endmodule

// File: rtl/ic_ctx_gate.sv
// Qualification of all sources for one context.
// A source qualifies when pending, unclaimed, enabled and of a priority
// strictly above the threshold; notify is the OR of the result.
// Assumes: purely combinational, inputs come from registers.
module ic_ctx_gate #(
    parameter int N_SRC  = 40,
    parameter int PRIO_W = 3
) (
    input  logic [N_SRC-1:0]             pend,
    input  logic [N_SRC-1:0]             claimed,
    input  logic [N_SRC-1:0]             en_mask,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]            thresh,
    output logic [N_SRC-1:0]             qual,
    output logic                         notify
);

    // Per-source eligibility and strict priority test.
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        assign qual[s] = pend[s] & ~claimed[s] & en_mask[s] & (prio[s] > thresh);
    end

    // Any qualifying source raises the context's line.
    assign notify = |qual;

endmodule

// File: rtl/ic_first_pick.sv
// Lowest-index selection over a request vector, built as a per-group
// encoder over fixed-width groups followed by a group select.
// Assumes: hit is low and idx is zero when no request is set.
module ic_first_pick #(
    parameter int N_SRC = 40,
    parameter int ID_W  = 6
) (
    input  logic [N_SRC-1:0] req,
    output logic             hit,
    output logic [ID_W-1:0]  idx
);

    localparam int GW    = ic_pkg::GROUP_W;
    localparam int N_GRP = (N_SRC + GW - 1) / GW;
    localparam int PAD   = N_GRP * GW;
    localparam int OFF_W = $clog2(GW);

    logic [PAD-1:0]   req_pad;
    logic             grp_hit [N_GRP];
    logic [OFF_W-1:0] grp_off [N_GRP];

    // Widen the request vector to whole groups.
    always_comb begin
        req_pad             = '0;
        req_pad[N_SRC-1:0]  = req;
    end

    // Find the lowest set bit inside each group.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        always_comb begin
            grp_hit[g] = |req_pad[g*GW +: GW];
            grp_off[g] = '0;
            for (int b = GW - 1; b >= 0; b--) begin
                if (req_pad[g*GW + b]) grp_off[g] = OFF_W'(b);
            end
        end
    end

    // Take the lowest group that holds a request.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int g = N_GRP - 1; g >= 0; g--) begin
            if (grp_hit[g]) begin
                hit = 1'b1;
                idx = ID_W'(g * GW) + ID_W'(grp_off[g]);
            end
        end
    end

endmodule

// File: rtl/ic_core.sv
// Interrupt claim and notify core: configuration storage, one gate per
// context, the claim picker, source flags and the registered response.
// Assumes: N_SRC >= 2, N_CTX >= 1; one command per cycle.
module ic_core #(
    parameter int N_SRC  = 40,
    parameter int N_CTX  = 3,
    parameter int PRIO_W = 3,
    parameter int ID_W   = $clog2(N_SRC),
    parameter int CTX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_lvl,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CTX_W-1:0]  cfg_ctx,
    input  logic [ID_W-1:0]   cfg_idx,
    input  logic [PRIO_W-1:0] cfg_data,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [CTX_W-1:0]  cmd_ctx,
    input  logic [ID_W-1:0]   cmd_id,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic [N_CTX-1:0]  notify
);

    import ic_pkg::*;

    localparam logic [ID_W:0] SRC_LIM = (ID_W + 1)'(N_SRC);

    logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [N_SRC-1:0]             en_q   [N_CTX];
    logic [PRIO_W-1:0]            thr_q  [N_CTX];
    logic [N_SRC-1:0]             qual   [N_CTX];
    logic [N_SRC-1:0]             pend_w;
    logic [N_SRC-1:0]             claim_w;
    logic [N_SRC-1:0]             qual_sel;
    logic                         pick_hit;
    logic [ID_W-1:0]              pick_idx;
    logic                         is_claim;
    logic                         grant_en;
    logic                         clr_en;
    logic                         idx_ok;
    cfg_sel_e                     sel;

    assign sel    = cfg_sel_e'(cfg_sel);
    assign idx_ok = ({1'b0, cfg_idx} < SRC_LIM);

    // Store source priorities from configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (cfg_we && sel == CFG_PRIO && idx_ok) begin
            prio_q[cfg_idx] <= cfg_data;
        end
    end

    // Per-context enable masks and thresholds.
    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        logic ctx_hit;
        assign ctx_hit = cfg_we && (cfg_ctx == CTX_W'(c));

        // Store this context's enable bits; source 0 is never enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[c] <= '0;
            end else if (ctx_hit && sel == CFG_ENABLE && idx_ok && cfg_idx != '0) begin
                en_q[c][cfg_idx] <= cfg_data[0];
            end
        end

        // Store this context's threshold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                thr_q[c] <= '0;
            end else if (ctx_hit && sel == CFG_THRESH) begin
                thr_q[c] <= cfg_data;
            end
        end

        ic_ctx_gate #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_gate (
            .pend    (pend_w),
            .claimed (claim_w),
            .en_mask (en_q[c]),
            .prio    (prio_q),
            .thresh  (thr_q[c]),
            .qual    (qual[c]),
            .notify  (notify[c])
        );
    end

    // Route the qualifying set of the claiming context; none if out of range.
    always_comb begin
        qual_sel = '0;
        for (int c = 0; c < N_CTX; c++) begin
            if (cmd_ctx == CTX_W'(c)) qual_sel = qual[c];
        end
    end

    ic_first_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pick (
        .req (qual_sel),
        .hit (pick_hit),
        .idx (pick_idx)
    );

    assign is_claim = cmd_valid && (cmd_op_e'(cmd_op) == OP_CLAIM);
    assign grant_en = is_claim && pick_hit;
    assign clr_en   = cmd_valid && (cmd_op_e'(cmd_op) == OP_COMPLETE)
                      && ({1'b0, cmd_id} < SRC_LIM);

    ic_src_state #(.N_SRC(N_SRC), .ID_W(ID_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  (src_lvl),
        .grant_en (grant_en),
        .grant_id (pick_idx),
        .clr_en   (clr_en),
        .clr_id   (cmd_id),
        .pend     (pend_w),
        .claimed  (claim_w)
    );

    // Register the claim answer; zero means nothing granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
        end else begin
            rsp_valid <= is_claim;
            rsp_id    <= grant_en ? pick_idx : '0;
        end
    end

endmodule

// File: rtl/ic_core_chk.sv
// Property checker for ic_core, attached through bind.
// Assumes: the flags it watches are the source-state outputs.
module ic_core_chk #(
    parameter int N_SRC = 40,
    parameter int ID_W  = 6,
    parameter int N_CTX = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_op,
    input logic [ID_W-1:0]  cmd_id,
    input logic             rsp_valid,
    input logic [ID_W-1:0]  rsp_id,
    input logic [N_CTX-1:0] notify,
    input logic [N_SRC-1:0] pend,
    input logic [N_SRC-1:0] claimed
);

    localparam logic [ID_W:0] LIM = (ID_W + 1)'(N_SRC);

    logic rsp_live;
    logic cmd_live;
    assign rsp_live = rsp_valid && (rsp_id != '0) && ({1'b0, rsp_id} < LIM);
    assign cmd_live = cmd_valid && cmd_op && ({1'b0, cmd_id} < LIM);

    AST_CLAIM_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_op) |=> rsp_valid); // R5
    AST_GRANT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_live |-> claimed[rsp_id]); // R5
    AST_GRANT_UNPENDED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_live |-> !pend[rsp_id]); // R10
    AST_SRC0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!pend[0] && !claimed[0])); // R9
    AST_NOTIFY_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (|notify) |-> (|(pend & ~claimed))); // R1
    AST_EMPTY_CLAIM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_id == '0) |-> $stable(claimed)); // R6
    AST_COMPLETE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_live |=> !claimed[$past(cmd_id)]); // R7

endmodule

bind ic_core ic_core_chk #(.N_SRC(N_SRC), .ID_W(ID_W), .N_CTX(N_CTX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_id    (cmd_id),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id),
    .notify    (notify),
    .pend      (pend_w),
    .claimed   (claim_w)
);

// File: tb/ic_core_test.sv
module ic_core_test;

    localparam int N_SRC  = 40;
    localparam int N_CTX  = 3;
    localparam int PRIO_W = 3;
    localparam int ID_W   = 6;
    localparam int CTX_W  = 2;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC-1:0]  src_lvl = '0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [CTX_W-1:0]  cfg_ctx = '0;
    logic [ID_W-1:0]   cfg_idx = '0;
    logic [PRIO_W-1:0] cfg_data = '0;
    logic              cmd_valid = 1'b0;
    logic              cmd_op = 1'b0;
    logic [CTX_W-1:0]  cmd_ctx = '0;
    logic [ID_W-1:0]   cmd_id = '0;
    logic              rsp_valid;
    logic [ID_W-1:0]   rsp_id;
    logic [N_CTX-1:0]  notify;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit m_pend [N_SRC];
    bit m_clm  [N_SRC];
    int m_prio [N_SRC];
    bit m_en   [N_CTX][N_SRC];
    int m_thr  [N_CTX];
    bit m_rv;
    int m_rid;

    always #(CLK_PERIOD/2) clk = ~clk;

    ic_core #(.N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(PRIO_W)) uut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ctx(cfg_ctx),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ctx(cmd_ctx), .cmd_id(cmd_id),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .notify(notify)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit m_qual(int c, int s);
        return s != 0 && m_pend[s] && !m_clm[s] && m_en[c][s] && m_prio[s] > m_thr[c];
    endfunction

    function automatic int m_notify();
        int v = 0;
        for (int c = 0; c < N_CTX; c++)
            for (int s = 0; s < N_SRC; s++)
                if (m_qual(c, s)) v |= (1 << c);
        return v;
    endfunction

    task automatic model_tick();
        int g = 0;
        bit claim = cmd_valid && !cmd_op;
        if (!rst_n) begin
            for (int s = 0; s < N_SRC; s++) begin
                m_pend[s] = 0; m_clm[s] = 0; m_prio[s] = 0;
                for (int c = 0; c < N_CTX; c++) m_en[c][s] = 0;
            end
            for (int c = 0; c < N_CTX; c++) m_thr[c] = 0;
            m_rv = 0; m_rid = 0;
            return;
        end
        if (claim && int'(cmd_ctx) < N_CTX)
            for (int s = N_SRC - 1; s > 0; s--)
                if (m_qual(int'(cmd_ctx), s)) g = s;
        for (int s = 1; s < N_SRC; s++) m_pend[s] = src_lvl[s];
        if (cmd_valid && cmd_op && int'(cmd_id) < N_SRC) m_clm[cmd_id] = 0;
        if (g != 0) begin m_pend[g] = 0; m_clm[g] = 1; end
        if (cfg_we) begin
            if (cfg_sel == 0 && int'(cfg_idx) < N_SRC) m_prio[cfg_idx] = int'(cfg_data);
            if (cfg_sel == 1 && int'(cfg_idx) < N_SRC && int'(cfg_ctx) < N_CTX && cfg_idx != 0)
                m_en[cfg_ctx][cfg_idx] = cfg_data[0];
            if (cfg_sel == 2 && int'(cfg_ctx) < N_CTX) m_thr[cfg_ctx] = int'(cfg_data);
        end
        m_rv = claim;
        m_rid = g;
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge.
    task automatic step();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        chk("R3 notify vs model", int'(notify), m_notify());
        chk("R4 response vs model", int'({rsp_valid, rsp_id}), (int'(m_rv) << ID_W) | m_rid);
        cmd_valid = 1'b0;
        cfg_we = 1'b0;
    endtask

    task automatic cfg(int sel, int ctx, int idx, int data);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_ctx = CTX_W'(ctx);
        cfg_idx = ID_W'(idx); cfg_data = PRIO_W'(data);
        step();
    endtask

    task automatic claim(int ctx);
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_ctx = CTX_W'(ctx);
        step();
    endtask

    task automatic complete(int id);
        cmd_valid = 1'b1; cmd_op = 1'b1; cmd_id = ID_W'(id);
        step();
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        repeat (198000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R11 reset notify", int'(notify), 0);
        chk("R11 reset rsp_valid", int'(rsp_valid), 0);

        cfg(0, 0, 5, 3);  cfg(0, 0, 9, 5);  cfg(0, 0, 35, 2);  cfg(0, 0, 36, 7);
        cfg(1, 0, 5, 1);  cfg(1, 0, 9, 1);  cfg(1, 0, 35, 1);  cfg(1, 0, 36, 1);
        cfg(1, 1, 35, 1); cfg(1, 2, 9, 1);
        cfg(2, 0, 0, 2);  cfg(2, 1, 0, 2);  cfg(2, 2, 0, 0);
        chk("R1 enabled but not pending", int'(notify), 0);

        src_lvl[9] = 1'b1; src_lvl[35] = 1'b1;
        step();
        chk("R8 level sets pending", int'(notify), 5);
        chk("R2 equal priority stays quiet", int'(notify[1]), 0);

        claim(0);
        chk("R5 grant valid", int'(rsp_valid), 1);
        chk("R5 grant id", int'(rsp_id), 9);
        chk("R1 claimed source hidden", int'(notify), 0);
        step();
        chk("R10 level high after grant stays hidden", int'(notify), 0);

        src_lvl[5] = 1'b1; src_lvl[36] = 1'b1;
        step();
        chk("R3 new pending raises ctx0", int'(notify), 1);
        claim(0);
        chk("R4 lowest number beats higher priority", int'(rsp_id), 5);
        claim(0);
        chk("R4 second group scanned", int'(rsp_id), 36);
        claim(0);
        chk("R6 empty claim returns zero", int'(rsp_id), 0);
        chk("R6 empty claim valid", int'(rsp_valid), 1);
        claim(1);
        chk("R2 equal priority not granted", int'(rsp_id), 0);

        complete(45);
        chk("R7 out-of-range complete ignored", int'(notify), 0);
        complete(9);
        chk("R7 complete releases source", int'(notify), 5);

        cfg(2, 0, 0, 5);
        chk("R2 threshold equal to priority", int'(notify), 4);
        cfg(2, 1, 0, 1);
        chk("R2 lower threshold admits source", int'(notify), 6);

        cfg(2, 3, 0, 7);
        cfg(1, 0, 50, 1);
        cfg(3, 2, 9, 7);
        chk("R12 ignored configuration writes", int'(notify), 6);
        claim(3);
        chk("R6 claim on absent context", int'(rsp_id), 0);

        claim(1);
        chk("R5 grant for ctx1", int'(rsp_id), 35);
        chk("R5 grant hides source", int'(notify), 4);

        src_lvl = '0;
        step();
        chk("R8 level low clears pending", int'(notify), 0);

        cfg(1, 2, 0, 1); cfg(0, 0, 0, 7);
        src_lvl[0] = 1'b1;
        step();
        chk("R9 source zero never notifies", int'(notify), 0);
        claim(2);
        chk("R9 source zero never granted", int'(rsp_id), 0);

        cfg(0, 0, 9, 7); cfg(2, 2, 0, 6);
        src_lvl[9] = 1'b1;
        step();
        chk("R9 full priority range", int'(notify), 5);

        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R11 reset clears enables", int'(notify), 0);

        for (int i = 0; i < 600; i++) begin
            src_lvl = {$urandom, $urandom} & {{8{1'b0}}, {32{1'b1}}} | (N_SRC'($urandom) << 32);
            if ($urandom_range(0, 9) < 4) begin
                cfg_we = 1'b1; cfg_sel = 2'($urandom_range(0, 3));
                cfg_ctx = CTX_W'($urandom_range(0, 3));
                cfg_idx = ID_W'($urandom_range(0, 45));
                cfg_data = PRIO_W'($urandom_range(0, 7));
            end
            if ($urandom_range(0, 1) == 1) begin
                cmd_valid = 1'b1; cmd_op = 1'($urandom_range(0, 1));
                cmd_ctx = CTX_W'($urandom_range(0, 3));
                cmd_id = ID_W'($urandom_range(0, 63));
            end
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule